// File: doc/BRIEF.md
# Immediate-Controlled Word Shuffle

This block rearranges the 32-bit words of two 128-bit vector operands into a new 128-bit result under control of an 8-bit immediate. One operand is the previous value of the destination register. The other is a second source register. The two low result words come from the second source and the two high result words come from the old destination. Each result word has its own 2-bit selector, so any source word can be repeated, dropped or reordered within its half.

The shuffle itself is combinational and is offered on its own output. A registered copy of the result is also provided. It loads on a clock edge where the input valid strobe is high, and a valid flag follows the strobe by one cycle. Register-file access and instruction decode sit outside the block. When both operands name the same register, the caller drives the same value on both inputs.

Top module: `word_shuffle_unit`

## Requirements
- R1: Result word 0 (bits [31:0]) equals word imm[1:0] of `src_b`. Word k of any 128-bit operand occupies bits [32k+31:32k].
- R2: Result word 1 (bits [63:32]) equals word imm[3:2] of `src_b`.
- R3: Result word 2 (bits [95:64]) equals word imm[5:4] of `old_dst`.
- R4: Result word 3 (bits [127:96]) equals word imm[7:6] of `old_dst`.
- R5: Every source word is taken from the operand values before the result exists, so a word of `old_dst` whose position is overwritten by a lower result word can still be selected. Equal operands need no special handling.
- R6: `shuf_comb` responds in the same cycle as its inputs, with no clock edge involved.
- R7: `shuf_q` takes the value of `shuf_comb` on a rising clock edge where `in_valid` is 1, and holds its value on edges where `in_valid` is 0.
- R8: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R9: While `rst_n` is 0, `shuf_q` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Loads the output register on this edge |
| old_dst | input | 128 | Previous destination value, feeds result words 2 and 3 |
| src_b | input | 128 | Second source, feeds result words 0 and 1 |
| ctrl_imm | input | 8 | Four 2-bit word selectors, lane 0 in bits [1:0] |
| shuf_comb | output | 128 | Combinational shuffle result |
| shuf_q | output | 128 | Registered shuffle result |
| out_valid | output | 1 | High one cycle after an accepted input |

## Verification
A bad selector field or a swapped source shows up at once on `shuf_comb` as a word taken from the wrong position or the wrong operand, in the same cycle the immediate is applied. A faulty load enable or a lost valid shows up one edge later, as `shuf_q` holding a stale value or changing without a strobe, or as `out_valid` out of step with `in_valid`. Sweeping all 256 immediates with distinct word values in every position exposes any selector that is miswired, and operand pairs with equal values confirm that aliased registers behave the same.

// File: rtl/wshuf_pkg.sv
package wshuf_pkg;
  localparam int NLANES = 4;
  localparam int SEL_W  = 2;
  localparam int IMM_W  = NLANES * SEL_W;

  // Selector field of one result lane
  function automatic logic [SEL_W-1:0] lane_sel(input logic [IMM_W-1:0] imm, input int lane);
    return imm[lane*SEL_W +: SEL_W];
  endfunction

  // Lanes below the midpoint draw from the second source
  function automatic bit lane_from_src_b(input int lane);
    return lane < NLANES / 2;
  endfunction
endpackage

// File: rtl/wshuf_lane_pick.sv
module wshuf_lane_pick #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [WORD_W*NWORDS-1:0] vec,
  input  logic [SEL_W-1:0]         sel,
  output logic [WORD_W-1:0]        word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (sel == SEL_W'(i)) word = vec[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/wshuf_hold_reg.sv
module wshuf_hold_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);
  p_novalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !q_valid);
endmodule

// File: rtl/word_shuffle_unit.sv
module word_shuffle_unit
  import wshuf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [WORD_W*NLANES-1:0]   old_dst,
  input  logic [WORD_W*NLANES-1:0]   src_b,
  input  logic [IMM_W-1:0]           ctrl_imm,
  output logic [WORD_W*NLANES-1:0]   shuf_comb,
  output logic [WORD_W*NLANES-1:0]   shuf_q,
  output logic                       out_valid
);
  localparam int VEC_W = WORD_W * NLANES;

  // Per-lane picked words, named for the assertions
  logic [WORD_W-1:0] lane_word [NLANES];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic [VEC_W-1:0] src;
    assign sel = lane_sel(ctrl_imm, g);
    if (lane_from_src_b(g)) begin : g_low
      assign src = src_b;
    end else begin : g_high
      assign src = old_dst;
    end
    wshuf_lane_pick #(.WORD_W(WORD_W), .NWORDS(NLANES), .SEL_W(SEL_W)) u_pick (
      .vec (src),
      .sel (sel),
      .word(lane_word[g])
    );
    assign shuf_comb[g*WORD_W +: WORD_W] = lane_word[g];
  end

  wshuf_hold_reg #(.DATA_W(VEC_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .d      (shuf_comb),
    .q      (shuf_q),
    .q_valid(out_valid)
  );

  // Lane sources checked against the operand ports
  p_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_comb[WORD_W-1:0] == src_b[ctrl_imm[1:0]*WORD_W +: WORD_W]);
  p_lane1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_comb[2*WORD_W-1:WORD_W] == src_b[ctrl_imm[3:2]*WORD_W +: WORD_W]);
  p_lane2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_comb[3*WORD_W-1:2*WORD_W] == old_dst[ctrl_imm[5:4]*WORD_W +: WORD_W]);
  p_lane3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_comb[4*WORD_W-1:3*WORD_W] == old_dst[ctrl_imm[7:6]*WORD_W +: WORD_W]);
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |-> (shuf_q == '0 && !out_valid));
endmodule

// File: tb/tb_word_shuffle_unit.sv
module tb_word_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] old_dst = '0;
  logic [127:0] src_b = '0;
  logic [7:0]   ctrl_imm = '0;
  logic [127:0] shuf_comb, shuf_q;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  word_shuffle_unit dut (.*);

  // Reference: build result from an explicit word list
  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] b,
                                         input logic [7:0] imm);
    logic [31:0] bw [4];
    logic [31:0] dw [4];
    for (int k = 0; k < 4; k++) begin
      bw[k] = b[32*k +: 32];
      dw[k] = d[32*k +: 32];
    end
    return {dw[imm[7:6]], dw[imm[5:4]], bw[imm[3:2]], bw[imm[1:0]]};
  endfunction

  task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic t_reset();
    // R9: outputs cleared while reset is held
    @(negedge clk);
    in_valid = 1'b1; src_b = rnd128();
    @(negedge clk);
    check128("R9 shuf_q in reset", shuf_q, '0);
    check1("R9 out_valid in reset", out_valid, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_identity();
    // imm 0xE4: lanes pick words 0,1,2,3 -> {dst w3, dst w2, b w1, b w0}
    old_dst = 128'h33333333_22222222_11111111_00000000;
    src_b   = 128'hBBBB0003_BBBB0002_BBBB0001_BBBB0000;
    ctrl_imm = 8'hE4;
    #1;
    check128("R1 R2 R3 R4 identity", shuf_comb,
             128'h33333333_22222222_BBBB0001_BBBB0000);
    // R6: change immediate mid-cycle, result follows without an edge
    ctrl_imm = 8'h1B; // lane sels 3,2,1,0
    #1;
    check128("R6 same-cycle response", shuf_comb,
             128'h00000000_11111111_BBBB0002_BBBB0003);
  endtask

  task automatic t_overlap();
    // R5: lane 2 reads dst word 0, lane 3 reads dst word 1 (positions overwritten low)
    old_dst = 128'hD3D3D3D3_D2D2D2D2_D1D1D1D1_D0D0D0D0;
    src_b   = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
    ctrl_imm = 8'b01_00_11_10;
    #1;
    check128("R5 old words still selectable", shuf_comb,
             128'hD1D1D1D1_D0D0D0D0_B3B3B3B3_B2B2B2B2);
  endtask

  task automatic t_sweep();
    // R1..R4 with every immediate; distinct and equal operand pairs
    for (int i = 0; i < 256; i++) begin
      logic [127:0] d, b;
      d = rnd128();
      b = rnd128();
      old_dst = d; src_b = b; ctrl_imm = 8'(i);
      #1;
      check128("R1 R2 R3 R4 sweep", shuf_comb, model(d, b, 8'(i)));
      src_b = d; // R5 aliased registers
      #1;
      check128("R5 equal operands", shuf_comb, model(d, d, 8'(i)));
      @(negedge clk);
    end
  endtask

  task automatic t_register();
    logic [127:0] exp_q;
    // R7 and R8: load with strobe
    @(negedge clk);
    old_dst = rnd128(); src_b = rnd128(); ctrl_imm = 8'h9C; in_valid = 1'b1;
    exp_q = model(old_dst, src_b, 8'h9C);
    @(negedge clk);
    check128("R7 load on strobe", shuf_q, exp_q);
    check1("R8 valid follows strobe", out_valid, 1'b1);
    // R7: strobe low, inputs change, register holds
    in_valid = 1'b0;
    old_dst = rnd128(); src_b = rnd128(); ctrl_imm = 8'h27;
    @(negedge clk);
    check128("R7 hold without strobe", shuf_q, exp_q);
    check1("R8 valid drops", out_valid, 1'b0);
    @(negedge clk);
    check128("R7 still held", shuf_q, exp_q);
    // back-to-back loads
    for (int n = 0; n < 4; n++) begin
      old_dst = rnd128(); src_b = rnd128(); ctrl_imm = 8'($urandom()); in_valid = 1'b1;
      exp_q = model(old_dst, src_b, ctrl_imm);
      @(negedge clk);
      check128("R7 back-to-back load", shuf_q, exp_q);
      check1("R8 back-to-back valid", out_valid, 1'b1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check1("R8 valid low after burst", out_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_overlap();
    t_sweep();
    t_register();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule